// File: doc/BRIEF.md
# Power-Down Clock Output Gating

This block sits between a set of free-running clock sources and the output pins of a system clock generator. It takes seven source clocks: a CPU group, an SDRAM group, a PCI group, a 66 MHz hub group, an IOAPIC group, a fixed-frequency group and a reference group. It produces one gated copy of its group's source clock for every output pin. Three controls decide what reaches the pins. The first is a power-down pin, which is asynchronous and active low. The second is a per-output enable vector that comes from configuration registers. The third is a global bit that asks for every output to be floated.

Each output is opened and closed by a register clocked on the falling edge of its own source clock. A change in gating therefore lands only while that source is low. An output that is stopped finishes its current high phase in full. An output that restarts begins with a complete high phase. The power-down pin first passes through a sampling filter clocked by the CPU source. A request counts only after two consecutive CPU rising edges have both seen the pin low. Each group has its own reset synchroniser on the edge that the group's logic uses.

Top module: `pd_clock_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` stays low. After `rst_n` rises, every enabled output resumes following its source clock.
- R2: A power-down request is accepted only when `pd_n` has been sampled low on two consecutive rising edges of the CPU source (`src_clk[0]`). A low level that spans a single such edge leaves every output running.
- R3: Once power-down is accepted, each output is held low from its own source's next falling edge onward. It stays low for as long as the request stays accepted.
- R4: Every high phase on any bit of `clk_out` lasts exactly one high phase of its source clock. This holds for any timing of `pd_n` and `out_en` changes.
- R5: A single CPU rising edge that samples `pd_n` high ends the request. Each output's gate reopens at the next falling edge of its source, and its first rising edge is the following source rising edge. For a CPU output this first rising edge comes two CPU rising edges after `pd_n` rises.
- R6: An `out_en` bit at 0 holds its output low, and a bit at 1 lets the output follow its source. A change takes effect at the next falling edge of that output's source. Bit positions by group are: CPU [1:0], SDRAM [14:2], PCI [22:15], 66 MHz [25:23], IOAPIC [26], fixed [28:27], reference [29]. The same positions apply to `clk_out`.
- R7: `out_oe` is 0 while `tri_all` is 1, and 1 while `tri_all` is 0. The gated clocks keep running either way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through synchronisers |
| src_clk | input | 7 | Free-running source clocks; bit 0 CPU, then SDRAM, PCI, 66 MHz, IOAPIC, fixed, reference |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| out_en | input | 30 | Per-output enable, 1 = run, 0 = held low |
| tri_all | input | 1 | Global float request, 1 = all outputs high impedance |
| clk_out | output | 30 | Gated output clocks |
| out_oe | output | 1 | Output driver enable, 0 while floating is requested |

## Verification
The hardest case to produce from the ports is a power-down pulse that straddles exactly one CPU rising edge. Close behind it comes a gating change that lands in the middle of a slow group's high phase. To reach both, the bench applies every stimulus one nanosecond after a CPU rising edge. It also runs the non-CPU sources with half periods of 3 to 8 ns and a 0.3 ns phase offset, so stimulus never coincides with any source edge. This lets it place a one-edge pulse on purpose and then drive a long pseudo-random storm of enable and power-down changes. A width monitor on every output flags any high phase shorter or longer than its source's.

// File: rtl/pd_clock_gate_pkg.sv
`timescale 1ns/1ps
package pd_clock_gate_pkg;

  // Number of independent source clock groups.
  localparam int NUM_GRP = 7;

  // Index of each group inside src_clk; CPU must stay at 0 because the
  // power-down sampler is clocked by it.
  typedef enum int {
    GRP_CPU   = 0,
    GRP_SDRAM = 1,
    GRP_PCI   = 2,
    GRP_66M   = 3,
    GRP_APIC  = 4,
    GRP_FIXED = 5,
    GRP_REF   = 6
  } grp_idx_e;

  // Consecutive low samples needed before power-down is accepted.
  localparam int DEF_PD_SAMPLES = 2;

  // Depth of each reset synchroniser.
  localparam int DEF_RST_STAGES = 2;

endpackage

// File: rtl/pdcg_reset_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release; the release edge polarity is
// chosen so that it matches the edge of the logic being reset.
module pdcg_reset_sync #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pdcg_pd_sync.sv
`timescale 1ns/1ps
// Samples the asynchronous power-down pin on CPU rising edges and accepts
// the request only while all of the last SAMPLES samples were low.
module pdcg_pd_sync #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic pd_req
);

  logic [SAMPLES-1:0] smp_q;
  logic [SAMPLES-1:0] smp_d;

  always_comb begin
    smp_d = {smp_q[SAMPLES-2:0], pd_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '1;
    end else begin
      smp_q <= smp_d;
    end
  end

  // Accepted when every stored sample is low.
  assign pd_req = ~|smp_q;

endmodule

// File: rtl/pdcg_group_gate.sv
`timescale 1ns/1ps
// One clock group: a falling-edge gate register per output, ANDed with the
// group's source clock. Gate changes therefore only land while the source
// is low, so no high phase is ever cut short.
module pdcg_group_gate #(
  parameter int W = 1
) (
  input  logic         src_clk,
  input  logic         rst_n,
  input  logic         pd_req,
  input  logic [W-1:0] en,
  output logic [W-1:0] clk_out
);

  logic [W-1:0] gate_q;
  logic [W-1:0] gate_d;

  always_comb begin
    if (pd_req) begin
      gate_d = '0;
    end else begin
      gate_d = en;
    end
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else begin
      gate_q <= gate_d;
    end
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign clk_out[i] = src_clk & gate_q[i];
    end
  endgenerate

endmodule

// File: rtl/pd_clock_gate.sv
`timescale 1ns/1ps
module pd_clock_gate
  import pd_clock_gate_pkg::*;
#(
  parameter int CPU_W      = 2,
  parameter int SDR_W      = 13,
  parameter int PCI_W      = 8,
  parameter int M66_W      = 3,
  parameter int APIC_W     = 1,
  parameter int FIX_W      = 2,
  parameter int REF_W      = 1,
  parameter int PD_SAMPLES = DEF_PD_SAMPLES,
  parameter int RST_STAGES = DEF_RST_STAGES,
  localparam int N_OUT     = CPU_W + SDR_W + PCI_W + M66_W + APIC_W + FIX_W + REF_W
) (
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] src_clk,
  input  logic               pd_n,
  input  logic [N_OUT-1:0]   out_en,
  input  logic               tri_all,
  output logic [N_OUT-1:0]   clk_out,
  output logic               out_oe
);

  localparam int GW  [NUM_GRP] = '{CPU_W, SDR_W, PCI_W, M66_W, APIC_W, FIX_W, REF_W};
  localparam int OFF [NUM_GRP] = '{0,
                                   CPU_W,
                                   CPU_W + SDR_W,
                                   CPU_W + SDR_W + PCI_W,
                                   CPU_W + SDR_W + PCI_W + M66_W,
                                   CPU_W + SDR_W + PCI_W + M66_W + APIC_W,
                                   CPU_W + SDR_W + PCI_W + M66_W + APIC_W + FIX_W};

  logic               cpu_rst_n;
  logic [NUM_GRP-1:0] grp_rst_n;
  logic               pd_req;

  // Reset for the rising-edge power-down sampler (R1).
  pdcg_reset_sync #(
    .STAGES    (RST_STAGES),
    .FALL_EDGE (1'b0)
  ) u_cpu_rst (
    .clk    (src_clk[GRP_CPU]),
    .arst_n (rst_n),
    .srst_n (cpu_rst_n)
  );

  // Power-down acceptance filter (R2, R5).
  pdcg_pd_sync #(
    .SAMPLES (PD_SAMPLES)
  ) u_pd_sync (
    .clk    (src_clk[GRP_CPU]),
    .rst_n  (cpu_rst_n),
    .pd_n   (pd_n),
    .pd_req (pd_req)
  );

  // One reset synchroniser and one gate bank per clock group (R3, R4, R6).
  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int LO = OFF[g];
      localparam int WD = GW[g];

      pdcg_reset_sync #(
        .STAGES    (RST_STAGES),
        .FALL_EDGE (1'b1)
      ) u_rst (
        .clk    (src_clk[g]),
        .arst_n (rst_n),
        .srst_n (grp_rst_n[g])
      );

      pdcg_group_gate #(
        .W (WD)
      ) u_gate (
        .src_clk (src_clk[g]),
        .rst_n   (grp_rst_n[g]),
        .pd_req  (pd_req),
        .en      (out_en[LO +: WD]),
        .clk_out (clk_out[LO +: WD])
      );
    end
  endgenerate

  // Driver enable for the pad ring (R7).
  assign out_oe = ~tri_all;

endmodule

// File: rtl/pd_clock_gate_chk.sv
`timescale 1ns/1ps
module pd_clock_gate_chk
  import pd_clock_gate_pkg::*;
#(
  parameter int CPU_W  = 2,
  parameter int SDR_W  = 13,
  parameter int PCI_W  = 8,
  parameter int M66_W  = 3,
  parameter int APIC_W = 1,
  parameter int FIX_W  = 2,
  parameter int REF_W  = 1,
  localparam int N_OUT = CPU_W + SDR_W + PCI_W + M66_W + APIC_W + FIX_W + REF_W
) (
  input logic [NUM_GRP-1:0] src_clk,
  input logic               pd_n,
  input logic [N_OUT-1:0]   out_en,
  input logic [N_OUT-1:0]   clk_out,
  input logic               cpu_rst_n,
  input logic [NUM_GRP-1:0] grp_rst_n,
  input logic               pd_req
);

  localparam int GW  [NUM_GRP] = '{CPU_W, SDR_W, PCI_W, M66_W, APIC_W, FIX_W, REF_W};
  localparam int OFF [NUM_GRP] = '{0,
                                   CPU_W,
                                   CPU_W + SDR_W,
                                   CPU_W + SDR_W + PCI_W,
                                   CPU_W + SDR_W + PCI_W + M66_W,
                                   CPU_W + SDR_W + PCI_W + M66_W + APIC_W,
                                   CPU_W + SDR_W + PCI_W + M66_W + APIC_W + FIX_W};

  // R2: acceptance follows two consecutive low samples of the pin.
  p_accept_two_low_r2: assert property (
    @(posedge src_clk[GRP_CPU]) disable iff (!cpu_rst_n)
    $rose(pd_req) |-> (!$past(pd_n) && !$past(pd_n, 2)));

  // R5: one high sample of the pin ends the request.
  p_release_one_high_r5: assert property (
    @(posedge src_clk[GRP_CPU]) disable iff (!cpu_rst_n)
    pd_n |=> !pd_req);

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      localparam int LO = OFF[g];
      localparam int WD = GW[g];

      // R3: a request seen at a falling edge keeps the whole group low
      // through the next high phase.
      p_pd_holds_low_r3: assert property (
        @(negedge src_clk[g]) disable iff (!grp_rst_n[g])
        pd_req |=> (clk_out[LO +: WD] == '0));

      // R6: an output disabled at a falling edge shows no high phase after it.
      p_disabled_low_r6: assert property (
        @(negedge src_clk[g]) disable iff (!grp_rst_n[g])
        (~out_en[LO +: WD] != '0) |=> ((clk_out[LO +: WD] & ~$past(out_en[LO +: WD])) == '0));

      // R5: with no request at the previous falling edge, the high phase now
      // ending shows exactly the enables sampled there.
      p_resume_follows_en_r5: assert property (
        @(negedge src_clk[g]) disable iff (!grp_rst_n[g])
        ($past(grp_rst_n[g]) && !$past(pd_req)) |-> (clk_out[LO +: WD] == $past(out_en[LO +: WD])));
    end
  endgenerate

endmodule

bind pd_clock_gate pd_clock_gate_chk #(
  .CPU_W  (CPU_W),
  .SDR_W  (SDR_W),
  .PCI_W  (PCI_W),
  .M66_W  (M66_W),
  .APIC_W (APIC_W),
  .FIX_W  (FIX_W),
  .REF_W  (REF_W)
) u_chk (
  .src_clk   (src_clk),
  .pd_n      (pd_n),
  .out_en    (out_en),
  .clk_out   (clk_out),
  .cpu_rst_n (cpu_rst_n),
  .grp_rst_n (grp_rst_n),
  .pd_req    (pd_req)
);

// File: tb/pd_clock_gate_tb.sv
`timescale 1ns/1ps
module pd_clock_gate_tb;

  localparam int NG    = 7;
  localparam int N_OUT = 30;
  localparam int OFF [NG] = '{0, 2, 15, 23, 26, 27, 29};
  localparam real HALF_NS [NG] = '{2.5, 3.0, 4.0, 5.0, 6.0, 7.0, 8.0};

  // Stimulus table: {pd_n, tri_all, out_en[29:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 30'h3FFF_FFFF},
    {1'b1, 1'b0, 30'h2AAA_AAAA},
    {1'b1, 1'b0, 30'h1555_5555},
    {1'b0, 1'b0, 30'h3FFF_FFFF},
    {1'b1, 1'b1, 30'h0000_0003},
    {1'b1, 1'b0, 30'h0000_0000}
  };

  logic              clk;
  logic              gen_clk [1:NG-1];
  logic [NG-1:0]     src_clk;
  logic              rst_n;
  logic              pd_n;
  logic [N_OUT-1:0]  out_en;
  logic              tri_all;
  logic [N_OUT-1:0]  clk_out;
  logic              out_oe;

  int          checks;
  int          errors;
  bit          done;
  bit          mon_on;
  bit          width_on;
  int          runt_cnt;
  int unsigned rise_cnt [N_OUT];
  realtime     rise_t   [N_OUT];

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  assign src_clk[0] = clk;
  for (genvar g = 1; g < NG; g++) begin : g_src
    initial begin
      gen_clk[g] = 1'b0;
      #0.3;
      forever #(HALF_NS[g]) gen_clk[g] = ~gen_clk[g];
    end
    assign src_clk[g] = gen_clk[g];
  end

  pd_clock_gate u_dut (
    .rst_n   (rst_n),
    .src_clk (src_clk),
    .pd_n    (pd_n),
    .out_en  (out_en),
    .tri_all (tri_all),
    .clk_out (clk_out),
    .out_oe  (out_oe)
  );

  function automatic int grp_of(int i);
    int g;
    g = 0;
    for (int k = 0; k < NG; k++) if (i >= OFF[k]) g = k;
    return g;
  endfunction

  // Rising-edge counters and high-phase width monitors (R4).
  for (genvar i = 0; i < N_OUT; i++) begin : g_mon
    always @(posedge clk_out[i]) begin
      if (mon_on) rise_cnt[i] = rise_cnt[i] + 1;
      rise_t[i] = $realtime;
    end
    always @(negedge clk_out[i]) begin
      real w;
      if (width_on) begin
        w = $realtime - rise_t[i];
        if (w < HALF_NS[grp_of(i)] - 0.001 || w > HALF_NS[grp_of(i)] + 0.001)
          runt_cnt = runt_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N_OUT; i++) rise_cnt[i] = 0;
  endtask

  function automatic int total_rises();
    int s;
    s = 0;
    for (int i = 0; i < N_OUT; i++) s += rise_cnt[i];
    return s;
  endfunction

  function automatic logic [N_OUT-1:0] active_mask();
    logic [N_OUT-1:0] m;
    for (int i = 0; i < N_OUT; i++) m[i] = (rise_cnt[i] != 0);
    return m;
  endfunction

  // Stimulus point: 1 ns after a CPU rising edge, clear of every source edge.
  task automatic sync_pt();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0]      lf;
    logic [N_OUT-1:0] exp_m;
    realtime          t1;
    int               dt_ps;
    checks = 0; errors = 0; done = 0;
    mon_on = 0; width_on = 0; runt_cnt = 0;
    clear_counts();
    rst_n = 1'b0; pd_n = 1'b1; tri_all = 1'b0; out_en = '1;

    // R1: outputs silent during reset
    mon_on = 1;
    repeat (10) @(negedge clk);
    #1;
    check(clk_out == '0, "R1", "outputs during reset", clk_out, 0);
    check(total_rises() == 0, "R1", "rising edges during reset", total_rises(), 0);
    mon_on = 0;
    sync_pt();
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    width_on = 1;

    // Table-driven patterns (R1, R3, R6, R7)
    for (int v = 0; v < NV; v++) begin
      sync_pt();
      pd_n    = VEC[v][31];
      tri_all = VEC[v][30];
      out_en  = VEC[v][29:0];
      repeat (30) @(posedge clk);
      #1;
      clear_counts();
      mon_on = 1;
      repeat (20) @(posedge clk);
      #1;
      mon_on = 0;
      exp_m = VEC[v][31] ? VEC[v][29:0] : '0;
      check(active_mask() == exp_m, VEC[v][31] ? "R6" : "R3",
            $sformatf("activity vector %0d", v), active_mask(), exp_m);
      check(out_oe == ~VEC[v][30], "R7", $sformatf("out_oe vector %0d", v),
            out_oe, ~VEC[v][30]);
    end
    check(runt_cnt == 0, "R4", "high-phase widths over table", runt_cnt, 0);

    sync_pt();
    pd_n = 1'b1; tri_all = 1'b0; out_en = '1;
    repeat (20) @(posedge clk);

    // R2: low level across one CPU rising edge is ignored
    sync_pt();
    clear_counts();
    mon_on = 1;
    pd_n = 1'b0;
    #5;
    pd_n = 1'b1;
    #45;
    mon_on = 0;
    check(rise_cnt[0] == 10, "R2", "cpu rises after one-edge pulse", rise_cnt[0], 10);

    repeat (10) @(posedge clk);

    // R2: two samples needed; CPU output shows exactly two more pulses
    sync_pt();
    clear_counts();
    mon_on = 1;
    pd_n = 1'b0;
    #50;
    mon_on = 0;
    check(rise_cnt[0] == 2, "R2", "cpu rises before stop", rise_cnt[0], 2);

    // R3: everything stays low while the request holds
    clear_counts();
    mon_on = 1;
    #100;
    mon_on = 0;
    check(total_rises() == 0 && clk_out == '0, "R3", "rises while powered down",
          total_rises(), 0);

    // R5: release; CPU output rises two CPU edges later (9 ns after change)
    sync_pt();
    t1 = $realtime;
    pd_n = 1'b1;
    @(posedge clk_out[0]);
    dt_ps = int'(($realtime - t1) * 1000.0);
    check(dt_ps == 9000, "R5", "cpu first rise delay ps", dt_ps, 9000);
    clear_counts();
    mon_on = 1;
    #100;
    mon_on = 0;
    check(active_mask() == '1, "R5", "all outputs resumed", active_mask(), '1);

    // R4 / R6: storm of enable and power-down changes mid-phase
    lf = 32'hACE1_2468;
    for (int j = 0; j < 80; j++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      out_en = lf[29:0];
      if (lf[31:30] == 2'b00) pd_n = ~pd_n;
      repeat (int'(lf[5:4]) + 1) @(posedge clk);
      #1;
    end
    pd_n = 1'b1;
    out_en = '1;
    repeat (20) @(posedge clk);
    check(runt_cnt == 0, "R4", "high-phase widths after storm", runt_cnt, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule